// File: doc/BRIEF.md
# Multiphase Clock Divider and Phase Selector

This block turns a fast clock into four related clock outputs. The outputs run at one quarter or one eighth of the fast rate, and their relative phases are set by a 2-bit code. From the same count it derives a half-rate output, a double-rate output and a duplicate copy of the four main outputs. The whole block sits in one clock domain. A per-cycle `adv` strobe stands for one edge of the fast source, and one strobe is the smallest phase step. A single shared position counter advances once per strobe. Each output is decoded from that counter minus a lag that the phase code selects. All outputs leave through registers with the same one-cycle latency.

Three active-low enables each gate one output group. A disabled group is forced high. A synchronous active-low reset clears the counter, and the outputs drop low one edge after the reset is first sampled. In test mode the first halving stage is skipped: the counter moves two positions per strobe, so the outputs run at twice their normal rate. The analog loop, the oscillator and the feedback path are outside this block.

Top module: `mcd_multiphase_div`

## Requirements
- R1: Each output register takes the value decoded from the counter position held just before that rising edge. With `test_en` low, `fout[0]` has a period of 4 advancing steps when `div8`=0 and 8 steps when `div8`=1. It is high for the first half of each period, counted from position 0.
- R2: With `ph_sel`=2'b00, all four `fout` bits are identical at every cycle.
- R3: With `ph_sel`=2'b01, the rising edge of `fout[k]` comes k quarter periods after that of `fout[0]`: lags of 1/2/3 steps in divide-by-4 mode and 2/4/6 steps in divide-by-8 mode.
- R4: With `ph_sel`=2'b10, `fout[1]` rises one step before `fout[0]`, `fout[2]` rises one step after it, and `fout[3]` rises a quarter period after it (1 step in divide-by-4 mode, 2 steps in divide-by-8 mode).
- R5: With `ph_sel`=2'b11, the rising edge of `fout[k]` lags that of `fout[0]` by exactly k steps, in both divide modes.
- R6: `half_out` rises together with every second rising edge of `fout[0]`, starting with the first edge after reset. Its period is twice that of `fout[0]` in every mode.
- R7: `dbl_out` equals `fout[0]` in divide-by-4 mode. In divide-by-8 mode it has half the period of `fout[0]` and rises with each rising edge of `fout[0]` and at each midpoint between them.
- R8: `oe_aux_n`=1 forces `half_out` and `dbl_out` high. `oe_main_n`=1 forces `fout` high. `oe_dup_n`=1 forces `fout_dup` high. Each enable takes effect at the next rising edge and leaves the counter running. When `oe_main_n` and `oe_dup_n` are both low, `fout_dup` equals `fout`. A disable takes priority over the reset-low forcing of R9.
- R9: A rising edge with `rst_n`=0 clears the counter and the half-rate toggle. The outputs of that edge still follow R1, and every edge after it while `rst_n` stays low drives the enabled outputs to 0. The first edge with `rst_n`=1 also drives 0 and does not advance the counter. From the next edge, the outputs follow R1 from position 0.
- R10: An edge with `adv`=0 leaves the counter and the half-rate toggle unchanged. The outputs therefore repeat from the second such edge on, and the sequence resumes where it stopped.
- R11: With `test_en`=1, each step advances the counter by two positions. The `fout[0]` period becomes 2 steps in divide-by-4 mode and 4 steps in divide-by-8 mode, and R6 and R7 keep holding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low sequencer clear |
| adv | input | 1 | Advance strobe: one fast-clock step per cycle it is high |
| div8 | input | 1 | 0: divide by 4, 1: divide by 8 |
| test_en | input | 1 | Skip the first halving stage (two positions per step) |
| ph_sel | input | 2 | Phase relationship code of the four main outputs |
| oe_aux_n | input | 1 | Active-low enable of half_out and dbl_out |
| oe_main_n | input | 1 | Active-low enable of fout |
| oe_dup_n | input | 1 | Active-low enable of fout_dup |
| fout | output | 4 | Four phase-related divided clocks |
| fout_dup | output | 4 | Duplicate of fout with its own enable |
| half_out | output | 1 | Clock at half the fout[0] rate, edge-aligned to it |
| dbl_out | output | 1 | Clock at the fout[0] rate or twice it |

## Verification
Reset and output disable can fall on the same edge. Both act on the same output registers: reset pulls an enabled group low, while a disable pulls it high. The bench provokes this by asserting `rst_n` low while `oe_main_n` is high and `oe_dup_n` is low. It then holds both conditions over two edges before releasing the disable. The judgement is that the main group stays all ones, that the duplicate group first shows the continuing sequence and then zeros, and that the main group drops to zero on the edge after the disable is lifted.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  localparam int DEF_CNT_W = 3;
  localparam int NUM_FOUT  = 4;

  typedef enum logic [1:0] {
    PH_ALIGN = 2'b00,
    PH_QUAD  = 2'b01,
    PH_SPLIT = 2'b10,
    PH_STAIR = 2'b11
  } ph_mode_e;

  // Lag, in counter positions, of output k behind output 0.
  // A negative value means the output leads.
  function automatic int phase_lag(int k, ph_mode_e mode, int qtr);
    int lag;
    lag = 0;
    case (mode)
      PH_ALIGN: lag = 0;
      PH_QUAD:  lag = k * qtr;
      PH_SPLIT: begin
        case (k)
          1:       lag = -1;
          2:       lag = 1;
          3:       lag = qtr;
          default: lag = 0;
        endcase
      end
      PH_STAIR: lag = k;
      default:  lag = 0;
    endcase
    return lag;
  endfunction

endpackage

// File: rtl/mcd_sequencer.sv
module mcd_sequencer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             div8,
  input  logic             test_en,
  output logic [CNT_W-1:0] cnt,
  output logic             hb,
  output logic             clr_q
);

  localparam logic [CNT_W-1:0] MASK_HI = '1;
  localparam logic [CNT_W-1:0] MASK_LO = MASK_HI >> 1;
  localparam logic [CNT_W:0]   STEP_1  = 1;
  localparam logic [CNT_W:0]   STEP_2  = 2;

  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] cur;
  logic [CNT_W:0]   sum;
  logic             wrap;

  always_comb begin
    mask = div8 ? MASK_HI : MASK_LO;
    cur  = cnt & mask;
    sum  = {1'b0, cur} + (test_en ? STEP_2 : STEP_1);
    wrap = (sum > {1'b0, mask});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      hb    <= 1'b0;
      clr_q <= 1'b1;
    end else if (clr_q) begin
      clr_q <= 1'b0;
    end else if (adv) begin
      cnt <= sum[CNT_W-1:0] & mask;
      if (wrap) hb <= ~hb;
    end
  end

  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv || clr_q) |=> ($stable(cnt) && $stable(hb)));

  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= !rst_n;

  always @(posedge clk) begin
    if (rst_seen) begin
      // R9
      clr_zero_chk: assert (cnt == '0 && hb == 1'b0 && clr_q);
    end
  end

endmodule

// File: rtl/mcd_phase_decode.sv
module mcd_phase_decode
  import mcd_pkg::*;
#(
  parameter int CNT_W   = 3,
  parameter int NUM_OUT = 4
) (
  input  logic [CNT_W-1:0]   cnt,
  input  logic               hb,
  input  logic               div8,
  input  ph_mode_e           ph_mode,
  output logic [NUM_OUT-1:0] fout,
  output logic               half,
  output logic               dbl
);

  localparam int LEN_HI = 1 << CNT_W;
  localparam int LEN_LO = LEN_HI / 2;

  int               len;
  int               half_len;
  int               qtr;
  logic [CNT_W-1:0] mask;

  always_comb begin
    len      = div8 ? LEN_HI : LEN_LO;
    half_len = len / 2;
    qtr      = len / 4;
    mask     = CNT_W'(len - 1);
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_tap
    logic [CNT_W-1:0] lagv;
    logic [CNT_W-1:0] pos;
    always_comb begin
      lagv    = CNT_W'(phase_lag(k, ph_mode, qtr));
      pos     = (cnt - lagv) & mask;
      fout[k] = (int'(pos) < half_len);
    end
  end

  // Half rate follows the wrap toggle; double rate uses the bit that
  // splits a low-mode period in two.
  always_comb begin
    half = ~hb;
    dbl  = ~cnt[CNT_W-2];
  end

endmodule

// File: rtl/mcd_out_stage.sv
module mcd_out_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         en_n,
  input  logic         clr,
  input  logic [W-1:0] val,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (en_n)     q <= '1;
    else if (clr) q <= '0;
    else          q <= val;
  end

  logic armed;
  logic en_n_d;
  logic clr_d;

  always_ff @(posedge clk) begin
    armed  <= 1'b1;
    en_n_d <= en_n;
    clr_d  <= clr;
  end

  always @(posedge clk) begin
    if (armed) begin
      if (en_n_d) begin
        // R8
        dis_high_chk: assert (q == '1);
      end
      if (!en_n_d && clr_d) begin
        // R9
        clr_low_chk: assert (q == '0);
      end
    end
  end

endmodule

// File: rtl/mcd_multiphase_div.sv
module mcd_multiphase_div
  import mcd_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       div8,
  input  logic       test_en,
  input  logic [1:0] ph_sel,
  input  logic       oe_aux_n,
  input  logic       oe_main_n,
  input  logic       oe_dup_n,
  output logic [3:0] fout,
  output logic [3:0] fout_dup,
  output logic       half_out,
  output logic       dbl_out
);

  localparam int NOUT = NUM_FOUT;

  logic [CNT_W-1:0] cnt;
  logic             hb;
  logic             clr_q;
  logic [NOUT-1:0]  dec_fout;
  logic             dec_half;
  logic             dec_dbl;
  logic [1:0]       aux_q;
  ph_mode_e         ph_mode;

  assign ph_mode = ph_mode_e'(ph_sel);

  mcd_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .div8    (div8),
    .test_en (test_en),
    .cnt     (cnt),
    .hb      (hb),
    .clr_q   (clr_q)
  );

  mcd_phase_decode #(.CNT_W(CNT_W), .NUM_OUT(NOUT)) u_dec (
    .cnt     (cnt),
    .hb      (hb),
    .div8    (div8),
    .ph_mode (ph_mode),
    .fout    (dec_fout),
    .half    (dec_half),
    .dbl     (dec_dbl)
  );

  mcd_out_stage #(.W(NOUT)) u_main (
    .clk  (clk),
    .en_n (oe_main_n),
    .clr  (clr_q),
    .val  (dec_fout),
    .q    (fout)
  );

  mcd_out_stage #(.W(NOUT)) u_dup (
    .clk  (clk),
    .en_n (oe_dup_n),
    .clr  (clr_q),
    .val  (dec_fout),
    .q    (fout_dup)
  );

  mcd_out_stage #(.W(2)) u_aux (
    .clk  (clk),
    .en_n (oe_aux_n),
    .clr  (clr_q),
    .val  ({dec_half, dec_dbl}),
    .q    (aux_q)
  );

  assign half_out = aux_q[1];
  assign dbl_out  = aux_q[0];

  // R2
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_sel == 2'b00) |-> (dec_fout == {NOUT{dec_fout[0]}}));

  // R6
  half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dec_half) && $stable(div8) && $stable(test_en)) |-> $rose(dec_fout[0]));

  // R5
  stair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_sel == 2'b11 && $past(ph_sel) == 2'b11 && $stable(div8) && !test_en &&
     !$past(test_en) && $past(adv) && $past(rst_n) && !$past(clr_q))
    |-> (dec_fout[1] == $past(dec_fout[0])));

endmodule

// File: tb/mcd_multiphase_div_test.sv
module mcd_multiphase_div_test;

  localparam int CLK_PERIOD = 10;
  localparam int RUN_STEPS  = 20;

  // {div8, test_en, ph_sel[1:0], lag1[2:0], lag2[2:0], lag3[2:0]}
  localparam logic [12:0] VECS [10] = '{
    {1'b0, 1'b0, 2'b00, 3'd0, 3'd0, 3'd0},
    {1'b0, 1'b0, 2'b01, 3'd1, 3'd2, 3'd3},
    {1'b0, 1'b0, 2'b10, 3'd3, 3'd1, 3'd1},
    {1'b0, 1'b0, 2'b11, 3'd1, 3'd2, 3'd3},
    {1'b1, 1'b0, 2'b00, 3'd0, 3'd0, 3'd0},
    {1'b1, 1'b0, 2'b01, 3'd2, 3'd4, 3'd6},
    {1'b1, 1'b0, 2'b10, 3'd7, 3'd1, 3'd2},
    {1'b1, 1'b0, 2'b11, 3'd1, 3'd2, 3'd3},
    {1'b0, 1'b1, 2'b00, 3'd0, 3'd0, 3'd0},
    {1'b1, 1'b1, 2'b00, 3'd0, 3'd0, 3'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n, adv, div8, test_en;
  logic [1:0] ph_sel;
  logic       oe_aux_n, oe_main_n, oe_dup_n;
  logic [3:0] fout, fout_dup;
  logic       half_out, dbl_out;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  // bench model state
  int  m_bv;
  bit  m_clr;
  int  m_lag1, m_lag2, m_lag3;

  mcd_multiphase_div uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .div8      (div8),
    .test_en   (test_en),
    .ph_sel    (ph_sel),
    .oe_aux_n  (oe_aux_n),
    .oe_main_n (oe_main_n),
    .oe_dup_n  (oe_dup_n),
    .fout      (fout),
    .fout_dup  (fout_dup),
    .half_out  (half_out),
    .dbl_out   (dbl_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [9:0] expect_vec(int bv, bit d8, bit clr, bit e0n, bit e1n, bit e2n,
                                            int l1, int l2, int l3);
    int         m, h;
    logic [3:0] f;
    logic       hf, db;
    logic [3:0] mainv, dupv;
    logic [1:0] auxv;
    m    = d8 ? 8 : 4;
    h    = m / 2;
    f[0] = ((bv % m) < h);
    f[1] = (((bv + 64 - l1) % m) < h);
    f[2] = (((bv + 64 - l2) % m) < h);
    f[3] = (((bv + 64 - l3) % m) < h);
    hf   = (((bv / m) % 2) == 0);
    db   = ((bv % 4) < 2);
    mainv = e1n ? 4'hF : (clr ? 4'h0 : f);
    dupv  = e2n ? 4'hF : (clr ? 4'h0 : f);
    auxv  = e0n ? 2'b11 : (clr ? 2'b00 : {hf, db});
    return {dupv, mainv, auxv};
  endfunction

  task automatic tick(input string tag);
    logic [9:0] exp_v;
    logic [9:0] got_v;
    exp_v = expect_vec(m_bv, div8, m_clr, oe_aux_n, oe_main_n, oe_dup_n, m_lag1, m_lag2, m_lag3);
    if (!rst_n) begin
      m_bv  = 0;
      m_clr = 1'b1;
    end else if (m_clr) begin
      m_clr = 1'b0;
    end else if (adv) begin
      m_bv = m_bv + (test_en ? 2 : 1);
    end
    @(posedge clk);
    @(negedge clk);
    got_v  = {fout_dup, fout, half_out, dbl_out};
    checks = checks + 1;
    if (got_v !== exp_v) begin
      fails = fails + 1;
      $display("FAIL %s: got dup=%b main=%b half,dbl=%b expected dup=%b main=%b half,dbl=%b",
               tag, got_v[9:6], got_v[5:2], got_v[1:0], exp_v[9:6], exp_v[5:2], exp_v[1:0]);
    end
  endtask

  function automatic string vec_tag(logic [12:0] v);
    string t;
    if (v[11]) t = "R11";
    else begin
      case (v[10:9])
        2'b00:   t = "R2";
        2'b01:   t = "R3";
        2'b10:   t = "R4";
        default: t = "R5";
      endcase
    end
    return $sformatf("%s R1 R6 R7 div8=%0b", t, v[12]);
  endfunction

  initial begin
    rst_n     = 1'b0;
    adv       = 1'b1;
    div8      = 1'b0;
    test_en   = 1'b0;
    ph_sel    = 2'b00;
    oe_aux_n  = 1'b0;
    oe_main_n = 1'b0;
    oe_dup_n  = 1'b0;
    m_lag1 = 0; m_lag2 = 0; m_lag3 = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    m_bv  = 0;
    m_clr = 1'b1;

    // R9: reset state, all enabled outputs low
    tick("R9 reset state");

    for (int i = 0; i < 10; i++) begin
      // first reset edge keeps the old mode
      rst_n = 1'b0;
      tick("R9 first reset edge");
      div8    = VECS[i][12];
      test_en = VECS[i][11];
      ph_sel  = VECS[i][10:9];
      m_lag1  = int'(VECS[i][8:6]);
      m_lag2  = int'(VECS[i][5:3]);
      m_lag3  = int'(VECS[i][2:0]);
      tick("R9 held reset");
      rst_n = 1'b1;
      tick("R9 release edge");
      for (int s = 0; s < RUN_STEPS; s++) tick(vec_tag(VECS[i]));
    end

    // Directed: divide by 8, stair code
    rst_n   = 1'b0;
    tick("R9 reset before directed");
    div8    = 1'b1;
    test_en = 1'b0;
    ph_sel  = 2'b11;
    m_lag1 = 1; m_lag2 = 2; m_lag3 = 3;
    tick("R9 held reset");
    rst_n = 1'b1;
    tick("R9 release edge");
    for (int s = 0; s < 6; s++) tick("R5 directed");

    // R10: advance strobe low
    adv = 1'b0;
    for (int s = 0; s < 3; s++) tick("R10 hold");
    adv = 1'b1;
    for (int s = 0; s < 3; s++) tick("R10 resume");

    // R8: each enable on its own
    oe_main_n = 1'b1;
    for (int s = 0; s < 2; s++) tick("R8 main disabled");
    oe_main_n = 1'b0;
    oe_dup_n  = 1'b1;
    for (int s = 0; s < 2; s++) tick("R8 dup disabled");
    oe_dup_n  = 1'b0;
    oe_aux_n  = 1'b1;
    for (int s = 0; s < 2; s++) tick("R8 aux disabled");
    oe_aux_n  = 1'b0;
    for (int s = 0; s < 3; s++) tick("R8 re-enabled continuation");

    // R8 + R9: reset and disable on the same edges
    oe_main_n = 1'b1;
    rst_n     = 1'b0;
    tick("R9 mid-run reset first edge, R8 main disabled");
    tick("R8 R9 disable wins over reset");
    oe_main_n = 1'b0;
    tick("R9 held reset main low");
    rst_n = 1'b1;
    tick("R9 release edge");
    for (int s = 0; s < 10; s++) tick("R9 R1 restart from position 0");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    done = 1'b1;
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails = fails + 1;
      $display("FAIL watchdog: got no completion expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule